// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointer Select

This block holds a 16-bit processor status word. The low byte carries the condition flags: extend, negative, zero, overflow and carry. The high byte carries the privileged controls: a two-bit trace field, the supervisor bit, the master bit and a three-bit interrupt priority mask. The block updates the word from four sources:

- a full-word write, honoured in full only while the supervisor bit is set;
- a flag-byte write;
- a flag update from the ALU;
- exception entry.

It also decodes the trace mode, the interrupt mask and the privilege state for the rest of the core.

Three banked stack pointers are kept alongside the status word: user, interrupt and master. The supervisor and master bits pick which of them serves as the architectural A7. The A7 read and write ports always reach the pointer that the status word selects at the end of the cycle. An instruction that switches stacks and touches A7 in the same cycle therefore uses the new stack. Two build options remove the master stack and the change-of-flow trace mode; when removed, the matching status bit is forced to zero.

Top module: `psr_stack_unit`

## Requirements
- R1: After reset the status word is 0x2700: supervisor set, mask 7, trace off, all flags clear. Trace mode reads none (0), the interrupt stack is selected (1), and all stack pointers are zero.
- R2: Bits 11 and 7..5 of the status word always read zero.
- R3: A full-word write made while the supervisor bit (13) is set stores every implemented bit. The bit positions are: T1=15, T0=14, supervisor=13, master=12, mask=10..8, X=4, N=3, Z=2, V=1, C=0.
- R4: A full-word write made while the supervisor bit is clear changes only bits 4..0; the high byte keeps its value.
- R5: A flag-byte write loads bits 4..0 from its data in either privilege state and leaves the high byte unchanged.
- R6: An ALU update of kind add (0) or subtract (1) does the following. N takes the result MSB, Z takes the zero indication and V takes the overflow indication. C takes the carry (on add) or the borrow (on subtract), and X takes the same value as C.
- R7: An ALU update of kind logic (2 or 3) sets N and Z from the result, clears V and C, and leaves X unchanged.
- R8: The trace output decodes T1T0 as follows: 00 gives none (0), 10 gives all instructions (1), 01 gives change of flow (2). The pattern 11 is stored as written and decodes as none.
- R9: The stack select is user (0) when the supervisor bit is clear, interrupt (1) when supervisor is set and master clear, and master (2) when both are set. A7 reads and writes reach only the selected pointer.
- R10: A7 reads and writes in a cycle that also updates the status word use the selection implied by the updated word.
- R11: Exception entry sets the supervisor bit and clears T1 and T0. It loads the interrupt mask when the load request is set and otherwise keeps the old mask. It keeps the master bit and the flags, and it overrides every other status update in the same cycle.
- R12: When several updates coincide, the full-word write wins over the flag-byte write, and the flag-byte write wins over the ALU update.
- R13: Without the master stack option, bit 12 reads zero and the interrupt stack serves supervisor mode. Without the change-of-flow trace option, bit 14 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_wr_i | input | 1 | Full-word status write strobe |
| sr_wdata_i | input | 16 | Full-word write data |
| ccr_wr_i | input | 1 | Flag-byte write strobe |
| ccr_wdata_i | input | 8 | Flag-byte write data |
| alu_upd_i | input | 1 | ALU flag update strobe |
| alu_kind_i | input | 2 | 0 add, 1 subtract, 2/3 logic |
| alu_msb_i | input | 1 | Result most significant bit |
| alu_zero_i | input | 1 | Result is zero |
| alu_cb_i | input | 1 | Carry out on add, borrow on subtract |
| alu_ovf_i | input | 1 | Signed overflow |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_mask_ld_i | input | 1 | Load a new interrupt mask on entry |
| exc_mask_i | input | 3 | New interrupt mask |
| a7_wr_i | input | 1 | A7 write strobe |
| a7_wdata_i | input | AW | A7 write data |
| a7_rdata_o | output | AW | A7 read data from the selected pointer |
| sr_o | output | 16 | Status word |
| trace_o | output | 2 | Decoded trace mode |
| imask_o | output | 3 | Interrupt priority mask |
| super_o | output | 1 | Supervisor state |
| stack_sel_o | output | 2 | Selected stack pointer |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **User-mode full-word write.** A design that ignored privilege would let user code raise its own mask or enter supervisor mode.
- **Undefined trace encoding 11.** A design that decoded it as a live mode would start tracing unpredictably. A design that filtered it on write would lose the stored bits.
- **Status write and A7 access in the same cycle.** A design that selected the stack from the old word would corrupt the stack that was just left.
- **Exception entry coinciding with full-word and flag writes.** A wrong priority would leave trace enabled or drop supervisor mode inside the handler.
- **Reduced build.** A reduced build that still stored the master or flow-trace bit would select a stack pointer that does not exist.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned SR_W    = 16;
  localparam int unsigned IMASK_W = 3;
  localparam int unsigned BIT_T1  = 15;
  localparam int unsigned BIT_T0  = 14;
  localparam int unsigned BIT_S   = 13;
  localparam int unsigned BIT_M   = 12;
  localparam int unsigned IMASK_LO = 8;
  localparam int unsigned BIT_X   = 4;
  localparam int unsigned BIT_N   = 3;
  localparam int unsigned BIT_Z   = 2;
  localparam int unsigned BIT_V   = 1;
  localparam int unsigned BIT_C   = 0;

  localparam logic [SR_W-1:0] SR_RESET  = 16'h2700;
  localparam logic [SR_W-1:0] ARCH_MASK = 16'hF71F;

  typedef enum logic [1:0] {TRC_NONE = 2'd0, TRC_ALL = 2'd1, TRC_FLOW = 2'd2} trace_e;
  typedef enum logic [1:0] {STK_USER = 2'd0, STK_INTR = 2'd1, STK_MSTR = 2'd2} stack_e;
  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_LOG = 2'd2, ALU_LOG2 = 2'd3} alu_kind_e;

  function automatic stack_e stack_of(input logic s, input logic m);
    if (!s)     return STK_USER;
    else if (m) return STK_MSTR;
    else        return STK_INTR;
  endfunction
endpackage

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter bit HAS_MASTER     = 1'b1,
  parameter bit HAS_FLOW_TRACE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sr_wr_i,
  input  logic [SR_W-1:0]    sr_wdata_i,
  input  logic               ccr_wr_i,
  input  logic [7:0]         ccr_wdata_i,
  input  logic               alu_upd_i,
  input  alu_kind_e          alu_kind_i,
  input  logic               alu_msb_i,
  input  logic               alu_zero_i,
  input  logic               alu_cb_i,
  input  logic               alu_ovf_i,
  input  logic               exc_entry_i,
  input  logic               exc_mask_ld_i,
  input  logic [IMASK_W-1:0] exc_mask_i,
  output logic [SR_W-1:0]    sr_q_o,
  output logic [SR_W-1:0]    sr_d_o
);
  localparam logic [SR_W-1:0] ONE_HOT_M  = SR_W'(1) << BIT_M;
  localparam logic [SR_W-1:0] ONE_HOT_T0 = SR_W'(1) << BIT_T0;
  localparam logic [SR_W-1:0] CFG_CLR    = (HAS_MASTER ? '0 : ONE_HOT_M) |
                                           (HAS_FLOW_TRACE ? '0 : ONE_HOT_T0);
  localparam logic [SR_W-1:0] IMPL_MASK  = ARCH_MASK & ~CFG_CLR;

  logic [SR_W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (exc_entry_i) begin
      sr_n[BIT_S]  = 1'b1;
      sr_n[BIT_T1] = 1'b0;
      sr_n[BIT_T0] = 1'b0;
      if (exc_mask_ld_i) sr_n[IMASK_LO +: IMASK_W] = exc_mask_i;
    end else if (sr_wr_i) begin
      if (sr_q[BIT_S]) sr_n = sr_wdata_i;
      else             sr_n[7:0] = sr_wdata_i[7:0];
    end else if (ccr_wr_i) begin
      sr_n[7:0] = ccr_wdata_i;
    end else if (alu_upd_i) begin
      sr_n[BIT_N] = alu_msb_i;
      sr_n[BIT_Z] = alu_zero_i;
      unique case (alu_kind_i)
        ALU_ADD, ALU_SUB: begin
          sr_n[BIT_V] = alu_ovf_i;
          sr_n[BIT_C] = alu_cb_i;
          sr_n[BIT_X] = alu_cb_i;
        end
        default: begin
          sr_n[BIT_V] = 1'b0;
          sr_n[BIT_C] = 1'b0;
        end
      endcase
    end
    sr_n = sr_n & IMPL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= SR_RESET & IMPL_MASK;
    else         sr_q <= sr_n;
  end

  assign sr_q_o = sr_q;
  assign sr_d_o = sr_n;
endmodule

// File: rtl/psr_trace_decode.sv
module psr_trace_decode
  import psr_pkg::*;
(
  input  logic [1:0] tfield_i,
  output trace_e     trace_o
);
  // tfield_i = {T1, T0}; 11 is reserved and treated as off
  always_comb begin
    unique case (tfield_i)
      2'b10:   trace_o = TRC_ALL;
      2'b01:   trace_o = TRC_FLOW;
      default: trace_o = TRC_NONE;
    endcase
  end
endmodule

// File: rtl/psr_stack_bank.sv
module psr_stack_bank
  import psr_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter bit          HAS_MASTER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stack_e        sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o
);
  localparam int unsigned NUM_SP = HAS_MASTER ? 3 : 2;

  logic [AW-1:0] bank [NUM_SP];

  for (genvar k = 0; k < NUM_SP; k++) begin : g_sp
    logic [AW-1:0] sp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    sp_q <= '0;
      else if (wr_i && (int'(sel_i) == k))            sp_q <= wdata_i;
    end
    assign bank[k] = sp_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_SP; k++) begin
      if (int'(sel_i) == k) rdata_o = bank[k];
    end
  end
endmodule

// File: rtl/psr_stack_unit.sv
module psr_stack_unit
  import psr_pkg::*;
#(
  parameter int unsigned AW             = 32,
  parameter bit          HAS_MASTER     = 1'b1,
  parameter bit          HAS_FLOW_TRACE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sr_wr_i,
  input  logic [15:0]   sr_wdata_i,
  input  logic          ccr_wr_i,
  input  logic [7:0]    ccr_wdata_i,
  input  logic          alu_upd_i,
  input  logic [1:0]    alu_kind_i,
  input  logic          alu_msb_i,
  input  logic          alu_zero_i,
  input  logic          alu_cb_i,
  input  logic          alu_ovf_i,
  input  logic          exc_entry_i,
  input  logic          exc_mask_ld_i,
  input  logic [2:0]    exc_mask_i,
  input  logic          a7_wr_i,
  input  logic [AW-1:0] a7_wdata_i,
  output logic [AW-1:0] a7_rdata_o,
  output logic [15:0]   sr_o,
  output logic [1:0]    trace_o,
  output logic [2:0]    imask_o,
  output logic          super_o,
  output logic [1:0]    stack_sel_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  trace_e          trace_dec;
  stack_e          sel_next;

  psr_status_reg #(
    .HAS_MASTER    (HAS_MASTER),
    .HAS_FLOW_TRACE(HAS_FLOW_TRACE)
  ) u_sr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_wr_i      (sr_wr_i),
    .sr_wdata_i   (sr_wdata_i),
    .ccr_wr_i     (ccr_wr_i),
    .ccr_wdata_i  (ccr_wdata_i),
    .alu_upd_i    (alu_upd_i),
    .alu_kind_i   (alu_kind_e'(alu_kind_i)),
    .alu_msb_i    (alu_msb_i),
    .alu_zero_i   (alu_zero_i),
    .alu_cb_i     (alu_cb_i),
    .alu_ovf_i    (alu_ovf_i),
    .exc_entry_i  (exc_entry_i),
    .exc_mask_ld_i(exc_mask_ld_i),
    .exc_mask_i   (exc_mask_i),
    .sr_q_o       (sr_q),
    .sr_d_o       (sr_d)
  );

  psr_trace_decode u_trc (
    .tfield_i({sr_q[BIT_T1], sr_q[BIT_T0]}),
    .trace_o (trace_dec)
  );

  // A7 follows the post-update selection
  assign sel_next = stack_of(sr_d[BIT_S], sr_d[BIT_M]);

  psr_stack_bank #(
    .AW        (AW),
    .HAS_MASTER(HAS_MASTER)
  ) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_next),
    .wr_i   (a7_wr_i),
    .wdata_i(a7_wdata_i),
    .rdata_o(a7_rdata_o)
  );

  assign sr_o        = sr_q;
  assign trace_o     = trace_dec;
  assign imask_o     = sr_q[IMASK_LO +: IMASK_W];
  assign super_o     = sr_q[BIT_S];
  assign stack_sel_o = stack_of(sr_q[BIT_S], sr_q[BIT_M]);
endmodule

// File: rtl/psr_stack_unit_chk.sv
module psr_stack_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sr_wr_i,
  input logic        ccr_wr_i,
  input logic [7:0]  ccr_wdata_i,
  input logic        alu_upd_i,
  input logic [1:0]  alu_kind_i,
  input logic        exc_entry_i,
  input logic        exc_mask_ld_i,
  input logic [2:0]  exc_mask_i,
  input logic [15:0] sr_o,
  input logic [1:0]  trace_o
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[11] == 1'b0) && (sr_o[7:5] == 3'b000));

  a_r4_user_sysbyte_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_entry_i && !sr_o[13]) |=> $stable(sr_o[15:8]));

  a_r5_ccr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_wr_i && !sr_wr_i && !exc_entry_i) |=> (sr_o[4:0] == $past(ccr_wdata_i[4:0])));

  a_r6_x_tracks_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && !alu_kind_i[1] && !ccr_wr_i && !sr_wr_i && !exc_entry_i)
      |=> (sr_o[4] == sr_o[0]));

  a_r8_undef_trace_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[15:14] == 2'b11) |-> (trace_o == 2'd0));

  a_r11_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> (sr_o[13] && (sr_o[15:14] == 2'b00)));

  a_r11_entry_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_entry_i && exc_mask_ld_i) |=> (sr_o[10:8] == $past(exc_mask_i)));
endmodule

bind psr_stack_unit psr_stack_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sr_wr_i      (sr_wr_i),
  .ccr_wr_i     (ccr_wr_i),
  .ccr_wdata_i  (ccr_wdata_i),
  .alu_upd_i    (alu_upd_i),
  .alu_kind_i   (alu_kind_i),
  .exc_entry_i  (exc_entry_i),
  .exc_mask_ld_i(exc_mask_ld_i),
  .exc_mask_i   (exc_mask_i),
  .sr_o         (sr_o),
  .trace_o      (trace_o)
);

// File: tb/sim_psr_stack_unit.sv
`timescale 1ns/1ps
module sim_psr_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_wr, ccr_wr, alu_upd, alu_msb, alu_zero, alu_cb, alu_ovf;
  logic        exc, exc_ld, a7_wr;
  logic [15:0] sr_wdata;
  logic [7:0]  ccr_wdata;
  logic [1:0]  alu_kind;
  logic [2:0]  exc_mask;
  logic [31:0] a7_wdata;

  logic [31:0] a7_rd0, a7_rd1;
  logic [15:0] sr0, sr1;
  logic [1:0]  trc0, trc1, sel0, sel1;
  logic [2:0]  im0, im1;
  logic        sup0, sup1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  psr_stack_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
    .ccr_wr_i(ccr_wr), .ccr_wdata_i(ccr_wdata),
    .alu_upd_i(alu_upd), .alu_kind_i(alu_kind), .alu_msb_i(alu_msb),
    .alu_zero_i(alu_zero), .alu_cb_i(alu_cb), .alu_ovf_i(alu_ovf),
    .exc_entry_i(exc), .exc_mask_ld_i(exc_ld), .exc_mask_i(exc_mask),
    .a7_wr_i(a7_wr), .a7_wdata_i(a7_wdata), .a7_rdata_o(a7_rd0),
    .sr_o(sr0), .trace_o(trc0), .imask_o(im0), .super_o(sup0), .stack_sel_o(sel0)
  );

  psr_stack_unit #(.HAS_MASTER(1'b0), .HAS_FLOW_TRACE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
    .ccr_wr_i(ccr_wr), .ccr_wdata_i(ccr_wdata),
    .alu_upd_i(alu_upd), .alu_kind_i(alu_kind), .alu_msb_i(alu_msb),
    .alu_zero_i(alu_zero), .alu_cb_i(alu_cb), .alu_ovf_i(alu_ovf),
    .exc_entry_i(exc), .exc_mask_ld_i(exc_ld), .exc_mask_i(exc_mask),
    .a7_wr_i(a7_wr), .a7_wdata_i(a7_wdata), .a7_rdata_o(a7_rd1),
    .sr_o(sr1), .trace_o(trc1), .imask_o(im1), .super_o(sup1), .stack_sel_o(sel1)
  );

  // {tag[39:36], op[35:32], data[31:16], expected status[15:0]}
  // op: 0 word write, 1 flag write, 2 add, 3 sub, 4 logic, 5 exception entry
  // ALU data: bit0 msb, bit1 zero, bit2 carry/borrow, bit3 overflow
  // exception data: bit3 mask load, bits2..0 mask
  localparam int NVEC = 14;
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd3,  4'd0, 16'hFFFF, 16'hF71F},
    {4'd5,  4'd1, 16'h0000, 16'hF700},
    {4'd6,  4'd2, 16'h0005, 16'hF719},
    {4'd7,  4'd4, 16'h0002, 16'hF714},
    {4'd6,  4'd3, 16'h0008, 16'hF702},
    {4'd11, 4'd5, 16'h000B, 16'h3302},
    {4'd11, 4'd5, 16'h0005, 16'h3302},
    {4'd3,  4'd0, 16'h0015, 16'h0015},
    {4'd4,  4'd0, 16'hFFE0, 16'h0000},
    {4'd4,  4'd0, 16'hA71F, 16'h001F},
    {4'd5,  4'd1, 16'h00EA, 16'h000A},
    {4'd11, 4'd5, 16'h000F, 16'h270A},
    {4'd3,  4'd0, 16'h4800, 16'h4000},
    {4'd7,  4'd4, 16'h000D, 16'h4008}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sr_wr = 0; ccr_wr = 0; alu_upd = 0; exc = 0; exc_ld = 0; a7_wr = 0;
    sr_wdata = '0; ccr_wdata = '0; alu_kind = '0; alu_msb = 0; alu_zero = 0;
    alu_cb = 0; alu_ovf = 0; exc_mask = '0; a7_wdata = '0;
  endtask

  // inputs set after a negedge; apply at posedge, return at next negedge idle
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_sr(input logic [15:0] d);
    sr_wr = 1; sr_wdata = d; tick();
  endtask

  task automatic wr_a7(input logic [31:0] d);
    a7_wr = 1; a7_wdata = d; tick();
  endtask

  task automatic apply_vec(input logic [3:0] op, input logic [15:0] d);
    case (op)
      4'd0: begin sr_wr = 1; sr_wdata = d; end
      4'd1: begin ccr_wr = 1; ccr_wdata = d[7:0]; end
      4'd2, 4'd3, 4'd4: begin
        alu_upd = 1;
        alu_kind = (op == 4'd2) ? 2'd0 : (op == 4'd3) ? 2'd1 : 2'd2;
        alu_msb = d[0]; alu_zero = d[1]; alu_cb = d[2]; alu_ovf = d[3];
      end
      default: begin exc = 1; exc_ld = d[3]; exc_mask = d[2:0]; end
    endcase
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sr", {16'h0, sr0}, 32'h2700);
    chk("R1 trace", {30'h0, trc0}, 32'd0);
    chk("R1 mask", {29'h0, im0}, 32'd7);
    chk("R1 super", {31'h0, sup0}, 32'd1);
    chk("R1 stack", {30'h0, sel0}, 32'd1);
    chk("R1 a7", a7_rd0, 32'h0);

    // R13 reduced build drops master and flow-trace bits
    wr_sr(16'hFFFF);
    chk("R13 sr", {16'h0, sr1}, 32'hA71F);
    chk("R13 stack", {30'h0, sel1}, 32'd1);
    chk("R13 trace", {30'h0, trc1}, 32'd1);
    chk("R3 full", {16'h0, sr0}, 32'hF71F);

    for (int i = 0; i < NVEC; i++) begin
      apply_vec(VEC[i][35:32], VEC[i][31:16]);
      chk(tag_name(VEC[i][39:36]), {16'h0, sr0}, {16'h0, VEC[i][15:0]});
      chk("R2 reserved", {16'h0, sr0 & 16'h08E0}, 32'h0);
    end

    // back to supervisor for trace tests
    exc = 1; tick();
    chk("R11 enter", {16'h0, sr0}, 32'h2008);

    // R8 trace decode
    wr_sr(16'h2000); chk("R8 none", {30'h0, trc0}, 32'd0);
    wr_sr(16'hA000); chk("R8 all", {30'h0, trc0}, 32'd1);
    wr_sr(16'h6000); chk("R8 flow", {30'h0, trc0}, 32'd2);
    wr_sr(16'hE000);
    chk("R8 undef stored", {16'h0, sr0}, 32'hE000);
    chk("R8 undef decode", {30'h0, trc0}, 32'd0);

    // R9 banked pointers
    wr_sr(16'h2000); chk("R9 sel intr", {30'h0, sel0}, 32'd1);
    wr_a7(32'h1111_1111);
    wr_sr(16'h3000); chk("R9 sel mstr", {30'h0, sel0}, 32'd2);
    wr_a7(32'h2222_2222);
    wr_sr(16'h0000); chk("R9 sel user", {30'h0, sel0}, 32'd0);
    wr_a7(32'h3333_3333);
    chk("R9 user rd", a7_rd0, 32'h3333_3333);
    exc = 1; tick();
    chk("R9 intr rd", a7_rd0, 32'h1111_1111);
    wr_sr(16'h3000);
    chk("R9 mstr rd", a7_rd0, 32'h2222_2222);

    // R10 same-cycle status write and A7 access
    sr_wr = 1; sr_wdata = 16'h2000; a7_wr = 1; a7_wdata = 32'h4444_4444;
    #2;
    chk("R10 rd before edge", a7_rd0, 32'h1111_1111);
    tick();
    chk("R10 wrote intr", a7_rd0, 32'h4444_4444);
    wr_sr(16'h3000);
    chk("R10 mstr kept", a7_rd0, 32'h2222_2222);

    // R11 entry overrides coincident writes
    sr_wr = 1; sr_wdata = 16'h0000; ccr_wr = 1; ccr_wdata = 8'h1F;
    exc = 1; exc_ld = 1; exc_mask = 3'd5;
    tick();
    chk("R11 override", {16'h0, sr0}, 32'h3500);

    // R12 priority
    sr_wr = 1; sr_wdata = 16'h2000; ccr_wr = 1; ccr_wdata = 8'h1F;
    alu_upd = 1; alu_cb = 1;
    tick();
    chk("R12 word wins", {16'h0, sr0}, 32'h2000);
    ccr_wr = 1; ccr_wdata = 8'h03; alu_upd = 1; alu_msb = 1; alu_cb = 1;
    tick();
    chk("R12 flag wins", {16'h0, sr0}, 32'h2003);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule